// File: doc/BRIEF.md
# Ack-Gated Round-Robin Leaf Arbiter

This cell arbitrates among a small group of request lines (four by default, two in the narrow variant). It is one leaf of a tree of arbiters. It reduces its local requests to a single request that it passes up to the next level. It then waits for that level to answer with an acknowledge. Only while that acknowledge is high does it drive a grant down to one of its own requesters.

The choice among local requesters is round-robin. A registered one-hot token marks the position with highest priority. For each token position there is one fixed-priority slice, and only the slice that the token selects is enabled. That slice picks the first active request, scanning upward from the token position and wrapping at the top.

The token moves on by exactly one position on every clock edge where the acknowledge is high and at least one local request is present. It does not jump past the winner. The upward request is built from the request inputs alone. The acknowledge therefore enters from a separate block with no combinational path back to it.

Top module: `arb_leaf_ackreq`

## Requirements
- R1: `up_req` is high exactly when at least one bit of `req_in` is high; it does not depend on `ack_in` or on the token.
- R2: While `ack_in` is low, every bit of `grant_out` is 0.
- R3: At most one bit of `grant_out` is high, and a grant bit is only ever high for an input whose request bit is high.
- R4: With `ack_in` high and at least one request, `grant_out` is one-hot. It selects the first requesting index p found by scanning p = t, t+1, ... modulo NUM_REQ, where t is the token position. Bit i of `grant_out` belongs to `req_in[i]`.
- R5: After reset the token sits at position 0, so with all requests high and `ack_in` high the first grant is bit 0.
- R6: On every rising clock edge where `ack_in` is high and at least one request is high, the token advances from t to (t+1) modulo NUM_REQ. From the last position it wraps to 0, whatever input won.
- R7: On a clock edge where `ack_in` is low, or no request is high, the token keeps its position.
- R8: With NUM_REQ = 2 the cell follows R1 to R7 with a two-input OR and a two-slice ring.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_in | input | NUM_REQ | Request lines from the lower level |
| up_req | output | 1 | Combined request to the parent level |
| ack_in | input | 1 | Acknowledge from the parent level |
| grant_out | output | NUM_REQ | Grant lines to the lower level, one-hot or zero |

## Verification
The bench builds two copies side by side: one with NUM_REQ = 4 and one with NUM_REQ = 2. The four-wide copy walks the token through the full ring. It reaches the case where the token position has no request and the winner lies below it after a wrap. The two-wide copy covers the narrow variant, where the ring wraps on every second advance and each slice sees only one competitor. Random requests and acknowledges with a fixed seed, mixed with directed holds and wraps, check that the token stays put across acknowledge-low and request-free cycles.

// File: rtl/rra_pkg.sv
package rra_pkg;

  localparam int unsigned MAX_REQ = 32;

  typedef logic [MAX_REQ-1:0] req_vec_t;

  // mask with the low n lanes set
  function automatic req_vec_t lane_mask(int unsigned n);
    if (n >= MAX_REQ) return '1;
    return (req_vec_t'(1) << n) - req_vec_t'(1);
  endfunction

  // move lane s down to lane 0 within an n-lane ring
  function automatic req_vec_t rotate_down(req_vec_t v, int unsigned s, int unsigned n);
    if (s == 0) return v & lane_mask(n);
    return ((v >> s) | (v << (n - s))) & lane_mask(n);
  endfunction

  // move lane 0 up to lane s within an n-lane ring
  function automatic req_vec_t rotate_up(req_vec_t v, int unsigned s, int unsigned n);
    if (s == 0) return v & lane_mask(n);
    return ((v << s) | (v >> (n - s))) & lane_mask(n);
  endfunction

  // keep only the lowest set bit
  function automatic req_vec_t lowest_one(req_vec_t v);
    return v & (~v + req_vec_t'(1));
  endfunction

endpackage

// File: rtl/arb_token_ring.sv
module arb_token_ring
  import rra_pkg::*;
#(
  parameter int unsigned NUM_REQ = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step_i,
  output logic [NUM_REQ-1:0] token_o
);

  logic [NUM_REQ-1:0] token_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      token_q <= NUM_REQ'(1);
    end else if (step_i) begin
      token_q <= NUM_REQ'(rotate_up(req_vec_t'(token_q), 1, NUM_REQ));
    end
  end

  assign token_o = token_q;

  // R6: exactly one token position at all times
  a_r6_token_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(token_q));

  // R6: a step moves the token one place up, wrapping at the top
  a_r6_token_step: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> token_q == (($past(token_q) << 1) | ($past(token_q) >> (NUM_REQ - 1))));

  // R7: no step, no movement
  a_r7_token_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(token_q));

endmodule

// File: rtl/arb_prio_slice.sv
module arb_prio_slice
  import rra_pkg::*;
#(
  parameter int unsigned NUM_REQ = 4,
  parameter int unsigned START   = 0
) (
  input  logic               en_i,
  input  logic [NUM_REQ-1:0] req_i,
  output logic [NUM_REQ-1:0] grant_o
);

  localparam int unsigned SHIFT = START % NUM_REQ;

  logic [NUM_REQ-1:0] seen_w;
  logic [NUM_REQ-1:0] first_w;

  // view the requests with lane SHIFT at the bottom
  assign seen_w  = NUM_REQ'(rotate_down(req_vec_t'(req_i), SHIFT, NUM_REQ));
  assign first_w = NUM_REQ'(lowest_one(req_vec_t'(seen_w)));
  assign grant_o = en_i ? NUM_REQ'(rotate_up(req_vec_t'(first_w), SHIFT, NUM_REQ))
                        : '0;

endmodule

// File: rtl/arb_leaf_ackreq.sv
module arb_leaf_ackreq
  import rra_pkg::*;
#(
  parameter int unsigned NUM_REQ = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REQ-1:0] req_in,
  output logic               up_req,
  input  logic               ack_in,
  output logic [NUM_REQ-1:0] grant_out
);

  if (NUM_REQ < 2 || NUM_REQ > MAX_REQ) begin : g_bad_width
    $error("arb_leaf_ackreq: NUM_REQ out of range");
  end

  logic [NUM_REQ-1:0] token_w;
  logic [NUM_REQ-1:0] slice_grant [NUM_REQ];
  logic [NUM_REQ-1:0] arb_pick;
  logic               adv_token;

  // upward request uses only the request inputs: no path from ack_in
  assign up_req    = |req_in;
  assign adv_token = ack_in & up_req;

  arb_token_ring #(.NUM_REQ(NUM_REQ)) u_ring (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_i  (adv_token),
    .token_o (token_w)
  );

  for (genvar k = 0; k < NUM_REQ; k++) begin : g_slice
    arb_prio_slice #(.NUM_REQ(NUM_REQ), .START(k)) u_slice (
      .en_i    (token_w[k]),
      .req_i   (req_in),
      .grant_o (slice_grant[k])
    );
  end

  always_comb begin
    arb_pick = '0;
    for (int k = 0; k < NUM_REQ; k++) begin
      arb_pick = arb_pick | slice_grant[k];
    end
  end

  assign grant_out = ack_in ? arb_pick : '0;

  // R1: any grant implies the upward request was raised
  a_r1_grant_has_upreq: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant_out) |-> up_req);

  // R2: no acknowledge, no grant
  a_r2_ack_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_in |-> grant_out == '0);

  // R3: at most one grant, only to a requester
  a_r3_onehot0: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_out));

  a_r3_only_requesters: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_out & ~req_in) == '0);

  // R4: acknowledged pending request always yields a winner
  a_r4_served: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_in && (req_in != '0)) |-> $onehot(grant_out));

  // R4: the winner comes from the slice the token enables
  a_r4_single_slice: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(arb_pick) == ((req_in != '0) ? 1 : 0));

endmodule

// File: tb/tb_arb_leaf_ackreq.sv
`timescale 1ns/1ps
module tb_arb_leaf_ackreq;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [3:0] req4 = '0;
  logic       ack4 = 1'b0;
  logic       up4;
  logic [3:0] g4;
  logic [1:0] req2 = '0;
  logic       ack2 = 1'b0;
  logic       up2;
  logic [1:0] g2;

  int  checks = 0;
  int  fails  = 0;
  int  tok4   = 0;
  int  tok2   = 0;
  bit  done   = 1'b0;

  arb_leaf_ackreq #(.NUM_REQ(4)) dut (
    .clk(clk), .rst_n(rst_n), .req_in(req4), .up_req(up4),
    .ack_in(ack4), .grant_out(g4)
  );

  arb_leaf_ackreq #(.NUM_REQ(2)) dut2 (
    .clk(clk), .rst_n(rst_n), .req_in(req2), .up_req(up2),
    .ack_in(ack2), .grant_out(g2)
  );

  // scan from the token position upward with wrap; one-hot of the winner
  function automatic int exp_pick(int r, int t, int n, bit a);
    if (!a) return 0;
    for (int i = 0; i < n; i++) begin
      int idx = (t + i) % n;
      if (r[idx]) return 1 << idx;
    end
    return 0;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(logic [3:0] r4, logic a4, logic [1:0] r2, logic a2, string tag);
    @(negedge clk);
    req4 = r4; ack4 = a4; req2 = r2; ack2 = a2;
    #1;
    check({tag, " R1 up4"}, int'(up4), int'(r4 != 0));
    check({tag, " R4 g4"}, int'(g4), exp_pick(int'(r4), tok4, 4, a4));
    check({tag, " R8 R1 up2"}, int'(up2), int'(r2 != 0));
    check({tag, " R8 R4 g2"}, int'(g2), exp_pick(int'(r2), tok2, 2, a2));
    if (a4 && r4 != 0) tok4 = (tok4 + 1) % 4;
    if (a2 && r2 != 0) tok2 = (tok2 + 1) % 2;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1;
    check("R2 reset g4", int'(g4), 0);
    check("R2 reset g2", int'(g2), 0);
    rst_n = 1'b1;

    // R5: token starts at position 0
    step(4'b1111, 1'b1, 2'b11, 1'b1, "R5 first");
    check("R5 literal g4", int'(g4), 1);
    check("R5 literal g2", int'(g2), 1);
    step(4'b1111, 1'b1, 2'b11, 1'b1, "R6 adv");
    check("R6 literal g4", int'(g4), 2);
    check("R6 literal g2", int'(g2), 2);
    // token now at 2: requests 0 and 1 only -> wrap to input 0
    step(4'b0011, 1'b1, 2'b01, 1'b1, "R4 wrapwin");
    check("R4 literal g4", int'(g4), 1);
    // R2/R7: ack low with requests, token must hold at 3
    step(4'b1111, 1'b0, 2'b11, 1'b0, "R2 noack");
    check("R2 literal g4", int'(g4), 0);
    // R7: ack high with no requests, token holds
    step(4'b0000, 1'b1, 2'b00, 1'b1, "R7 noreq");
    check("R1 literal up4", int'(up4), 0);
    step(4'b1111, 1'b1, 2'b11, 1'b1, "R7 held");
    check("R7 literal g4", int'(g4), 8);
    // R6: wrap from the last position back to 0
    step(4'b1111, 1'b1, 2'b11, 1'b1, "R6 wrap");
    check("R6 wrap literal g4", int'(g4), 1);
    // R3: single requester gets it regardless of token
    step(4'b0100, 1'b1, 2'b10, 1'b1, "R3 single");
    check("R3 literal g4", int'(g4), 4);

    for (int n = 0; n < 4000; n++) begin
      logic [3:0] r4 = 4'($urandom);
      logic [1:0] r2 = 2'($urandom);
      logic a4 = ($urandom % 4) != 0;
      logic a2 = ($urandom % 4) != 0;
      step(r4, a4, r2, a2, "rand");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule